// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each of the four beats of a burst on a synchronous static memory. A burst begins when either of two address strobes is high at a rising clock edge. One strobe comes from the processor side and the other from the cache-controller side, and both capture the external address. After that, the block forms each address itself. It changes only the two least-significant bits, and only on clocks where the advance input is high. The upper address bits stay as they were loaded.

The ordering input is sampled together with the start address. When it is high, the low bits count upward and wrap within a group of four. When it is low, the low bits are the loaded low bits XORed with the beat number. This interleaved ordering suits processors that fill cache lines critical-word-first. When nothing is asserted, the address holds.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and until the synchronized release has passed, the address output is all zeros.
- R2: When either start strobe is high at a rising edge, the address output equals the sampled address input after that edge.
- R3: Both start strobes high together act the same as a single strobe and load the sampled address input.
- R4: With both strobes low and advance low, the address output keeps its value across the edge.
- R5: With linear ordering (ordering input 1 at load), each advance makes the low two bits equal to the loaded low bits plus the beat number, modulo 4. Starting from 1 the sequence is 1,2,3,0.
- R6: With interleaved ordering (ordering input 0 at load), each advance makes the low two bits equal to the loaded low bits XOR the beat number. Starting from 1 the sequence is 1,0,3,2.
- R7: Bits above bit 1 never change except on a load, including when the low bits wrap from 3 to 0.
- R8: When a start strobe and advance are high in the same cycle, the strobe wins: the address reloads and the beat number returns to 0.
- R9: The ordering is captured at load. Changing the ordering input during a burst has no effect on the addresses of that burst.
- R10: After four advances the beat number wraps, so the fifth address of a burst equals the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all inputs and state |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_in | input | ADDR_W | External start address |
| start_proc | input | 1 | Processor-side start strobe, active high |
| start_cache | input | 1 | Cache-controller-side start strobe, active high |
| advance | input | 1 | Steps to the next beat, active high |
| order_lin | input | 1 | Ordering select: 1 linear, 0 interleaved |
| addr_out | output | ADDR_W | Address of the current beat |

## Verification
Properties are checked on every cycle: a load shows the sampled address, an idle cycle holds, the upper bits stay fixed outside loads, a linear advance adds one to the low bits, and every advance flips bit 0. The full interleaved sequence needs a scenario, because its low bits depend on the loaded base. So do the wrap back to the first address after four beats and the fact that mid-burst changes to the ordering input are ignored. These are checked by the bench's reference model and by directed sequences.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic {
    ORD_INTERLEAVED = 1'b0,
    ORD_LINEAR      = 1'b1
  } order_t;
endpackage

// File: rtl/bag_rst_sync.sv
// Reset is asserted asynchronously; release passes through a flop chain.
module bag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bag_burst_state.sv
// Holds the loaded upper bits, the base low bits, the beat counter and
// the ordering captured at load.
module bag_burst_state
  import bag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     step,
  input  logic [ADDR_W-1:0]        addr_in,
  input  logic                     order_lin,
  output logic [ADDR_W-1:BEAT_W]   upper_q,
  output logic [BEAT_W-1:0]        base_q,
  output logic [BEAT_W-1:0]        beat_q,
  output order_t                   ord_q
);
  logic [ADDR_W-1:BEAT_W] upper_d;
  logic [BEAT_W-1:0]      base_d;
  logic [BEAT_W-1:0]      beat_d;
  order_t                 ord_d;
  logic                   upd_en;

  // Load has priority over step.
  always_comb begin
    upper_d = upper_q;
    base_d  = base_q;
    beat_d  = beat_q;
    ord_d   = ord_q;
    if (load) begin
      upper_d = addr_in[ADDR_W-1:BEAT_W];
      base_d  = addr_in[BEAT_W-1:0];
      beat_d  = '0;
      ord_d   = order_lin ? ORD_LINEAR : ORD_INTERLEAVED;
    end else if (step) begin
      beat_d  = beat_q + 1'b1;
    end
  end

  assign upd_en = load | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      base_q  <= '0;
      beat_q  <= '0;
      ord_q   <= ORD_INTERLEAVED;
    end else if (upd_en) begin
      upper_q <= upper_d;
      base_q  <= base_d;
      beat_q  <= beat_d;
      ord_q   <= ord_d;
    end
  end
endmodule

// File: rtl/bag_order_map.sv
// Maps base and beat number to the low address bits for the selected ordering.
module bag_order_map
  import bag_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] base,
  input  logic [BEAT_W-1:0] beat,
  input  order_t            ord,
  output logic [BEAT_W-1:0] low
);
  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] ilv_low;

  assign lin_low = base + beat;

  genvar i;
  generate
    for (i = 0; i < BEAT_W; i++) begin : g_xor
      assign ilv_low[i] = base[i] ^ beat[i];
    end
  endgenerate

  always_comb begin
    unique case (ord)
      ORD_LINEAR:      low = lin_low;
      default:         low = ilv_low;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BEAT_W    = 2,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              start_proc,
  input  logic              start_cache,
  input  logic              advance,
  input  logic              order_lin,
  output logic [ADDR_W-1:0] addr_out
);
  logic                   rst_sync_n;
  logic                   load;
  logic [ADDR_W-1:BEAT_W] upper_q;
  logic [BEAT_W-1:0]      base_q;
  logic [BEAT_W-1:0]      beat_q;
  order_t                 ord_q;
  logic [BEAT_W-1:0]      low;
  logic                   ord_is_lin;

  bag_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign load = start_proc | start_cache;

  bag_burst_state #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_state (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (load),
    .step      (advance),
    .addr_in   (addr_in),
    .order_lin (order_lin),
    .upper_q   (upper_q),
    .base_q    (base_q),
    .beat_q    (beat_q),
    .ord_q     (ord_q)
  );

  bag_order_map #(.BEAT_W(BEAT_W)) u_map (
    .base (base_q),
    .beat (beat_q),
    .ord  (ord_q),
    .low  (low)
  );

  assign ord_is_lin = (ord_q == ORD_LINEAR);
  assign addr_out   = {upper_q, low};
endmodule

// File: rtl/bag_chk.sv
module bag_chk #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_q,
  input logic [ADDR_W-1:0] addr_in,
  input logic              start_proc,
  input logic              start_cache,
  input logic              advance,
  input logic              ord_is_lin,
  input logic [ADDR_W-1:0] addr_out
);
  // R1
  always_comb begin
    if (!rst_q) begin
      reset_zero_chk: assert (addr_out == '0);
    end
  end

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (start_proc || start_cache) |=> addr_out == $past(addr_in));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!start_proc && !start_cache && !advance) |=> $stable(addr_out));

  // R7
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!start_proc && !start_cache) |=>
      addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));

  // R5
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (advance && !start_proc && !start_cache && ord_is_lin) |=>
      addr_out[BEAT_W-1:0] == BEAT_W'($past(addr_out[BEAT_W-1:0]) + 1'b1));

  // R6
  step_lsb_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (advance && !start_proc && !start_cache) |=>
      addr_out[0] != $past(addr_out[0]));
endmodule

bind burst_addr_gen bag_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk         (clk),
  .rst_q       (rst_sync_n),
  .addr_in     (addr_in),
  .start_proc  (start_proc),
  .start_cache (start_cache),
  .advance     (advance),
  .ord_is_lin  (ord_is_lin),
  .addr_out    (addr_out)
);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_in;
  logic          start_proc, start_cache, advance, order_lin;
  logic [AW-1:0] addr_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  logic [AW-1:2] m_up;
  logic [1:0]    m_base, m_beat;
  logic          m_lin;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .start_proc(start_proc), .start_cache(start_cache),
    .advance(advance), .order_lin(order_lin), .addr_out(addr_out)
  );

  function automatic logic [AW-1:0] exp_addr();
    logic [1:0] lo;
    lo = m_lin ? 2'(m_base + m_beat) : (m_base ^ m_beat);
    return {m_up, lo};
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_edge(bit sp, bit sc, bit adv, bit lin, logic [AW-1:0] a);
    if (sp || sc) begin
      m_up = a[AW-1:2]; m_base = a[1:0]; m_beat = 2'd0; m_lin = lin;
    end else if (adv) begin
      m_beat = m_beat + 2'd1;
    end
  endfunction

  // drive at negedge, update model at posedge, compare at next negedge
  task automatic cyc(input bit sp, input bit sc, input bit adv, input bit lin,
                     input logic [AW-1:0] a, input string tag);
    start_proc = sp; start_cache = sc; advance = adv; order_lin = lin; addr_in = a;
    @(posedge clk);
    model_edge(sp, sc, adv, lin, a);
    @(negedge clk);
    check(tag, addr_out, exp_addr());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_proc = 0; start_cache = 0; advance = 0; order_lin = 0; addr_in = '0;
    m_up = '0; m_base = '0; m_beat = '0; m_lin = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", addr_out, '0);
    rst_n = 1'b1;
    // inputs active during synchronized release are ignored
    start_proc = 1'b1; addr_in = 16'h1234;
    @(negedge clk);
    start_proc = 1'b0;
    check("R1 release", addr_out, '0);
    repeat (3) @(negedge clk);
    check("R1 after release", addr_out, '0);

    // linear from 1: 1,2,3,0,1
    cyc(1, 0, 0, 1, 16'hA5F1, "R2 proc load");
    check("R2 literal", addr_out, 16'hA5F1);
    cyc(0, 0, 1, 1, '0, "R5 lin beat1");
    check("R5 literal", addr_out, 16'hA5F2);
    cyc(0, 0, 1, 0, '0, "R9 mode flip");
    check("R9 literal", addr_out, 16'hA5F3);
    cyc(0, 0, 1, 0, '0, "R7 wrap low");
    check("R7 literal", addr_out, 16'hA5F0);
    cyc(0, 0, 0, 1, '0, "R4 hold");
    check("R4 literal", addr_out, 16'hA5F0);
    cyc(0, 0, 1, 1, '0, "R10 lin wrap");
    check("R10 literal", addr_out, 16'hA5F1);

    // interleaved from 1: 1,0,3,2,1
    cyc(0, 1, 0, 0, 16'h0FF1, "R2 cache load");
    cyc(0, 0, 1, 1, '0, "R6 ilv beat1");
    check("R6 literal b1", addr_out, 16'h0FF0);
    cyc(0, 0, 1, 1, '0, "R6 ilv beat2");
    check("R6 literal b2", addr_out, 16'h0FF3);
    cyc(0, 0, 1, 1, '0, "R6 ilv beat3");
    check("R6 literal b3", addr_out, 16'h0FF2);
    cyc(0, 0, 1, 0, '0, "R10 ilv wrap");
    check("R10 ilv literal", addr_out, 16'h0FF1);

    // upper bits across linear wrap from 3
    cyc(1, 1, 0, 1, 16'hFFFF, "R3 both strobes");
    check("R3 literal", addr_out, 16'hFFFF);
    cyc(0, 0, 1, 1, '0, "R7 upper on wrap");
    check("R7 literal wrap", addr_out, 16'hFFFC);

    // strobe beats advance
    cyc(0, 0, 1, 1, '0, "R5 step");
    cyc(1, 0, 1, 0, 16'h4442, "R8 strobe+adv");
    check("R8 literal", addr_out, 16'h4442);
    cyc(0, 0, 1, 0, '0, "R8 beat restart");
    check("R8 literal next", addr_out, 16'h4443);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      bit sp, sc, adv, lin;
      logic [AW-1:0] a;
      sp  = ($urandom % 8) == 0;
      sc  = ($urandom % 10) == 0;
      adv = ($urandom % 3) != 0;
      lin = $urandom % 2;
      a   = AW'($urandom);
      if (sp || sc)      cyc(sp, sc, adv, lin, a, sp && sc ? "R3 rand" : (adv ? "R8 rand" : "R2 rand"));
      else if (adv)      cyc(sp, sc, adv, lin, a, m_lin ? "R5 rand" : "R6 rand");
      else               cyc(sp, sc, adv, lin, a, "R4 rand");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule